// File: doc/BRIEF.md
# Split-Timeout and Bus-Time Register Unit

This block is a small slice of the control and status register space of a serial-bus node. It holds the two split-transaction timeout words, a cycle-time snapshot, a bus-time word and the broadcast-channel word. Each register has its own rule for which bits a write may change. From the split timeout it derives a transaction expiry in microseconds, and the node's transaction layer uses that value to give up on split transactions that never complete. When software reads the cycle-time or bus-time word, the block samples the link's free-running cycle counter again. A sample lower than the previous snapshot means the counter has wrapped, so the bus-time seconds advance by one step.

Requests arrive on a single port that carries a write flag, a byte address, a byte length and one write quadlet. A state machine with three states answers each request. In IDLE it accepts and decodes a request. IDLE->READ is taken for a clean read. IDLE->RESP is taken for a write or for any error. READ stays in READ and emits one data beat per cycle until the last beat, then goes READ->RESP. RESP drives the response code for one cycle and returns RESP->IDLE.

Register byte offsets within the slice: 0x00 timeout seconds, 0x04 timeout fraction, 0x08 cycle time, 0x0C bus time, 0x10 busy-timeout hole (not implemented), 0x14 broadcast channel.

Top module: `st_split_bus_regs`

## Requirements
- R1: A request whose address or length is not a multiple of 4, or whose length is 0, or a write whose length is not exactly 4, ends with response code 1 (type error) and no data beats.
- R2: A write to offset 0x00 keeps only bits 2:0. A write to offset 0x04 keeps only bits 31:19. All other bits read back as 0.
- R3: After reset, offset 0x00 reads 0 and offset 0x04 reads 0x19000000 (800 in bits 31:19). Offset 0x14 reads 0x8000001F, and expiry_us is 100000.
- R4: expiry_us equals seconds × 1000000 + fraction × 125, where seconds is bits 2:0 of 0x00 and fraction is bits 31:19 of 0x04. It never goes below 100000. It takes its new value in the cycle after a timeout write and changes at no other time.
- R5: Every read beat of 0x08 or 0x0C takes a new sample of cyc_count_in. If the sample is lower than the stored snapshot, the bus-time word increases by 128 (modulo 2^32). The sample then becomes the snapshot.
- R6: A read beat of 0x0C returns the bus-time word, after any R5 increase, ORed with the sample shifted right by 25. A write to 0x0C keeps only bits 31:7.
- R7: At 0x14 only bit 30 can be written. Bit 31 always reads 1 and bits 5:0 always read 31.
- R8: A request that touches offset 0x10, or any offset above 0x14, or a block read that continues past 0x0C, ends with response code 2 (address error). It returns no data and leaves every register unchanged.
- R9: A read of N quadlets returns N beats on consecutive cycles, with the registers in rising address order, followed by response code 0 (complete).
- R10: req_ready is high only in IDLE. Exactly one of req_ready, rd_valid and rsp_valid is high in every cycle. Every response lasts one cycle.
- R11: A write to 0x08 replaces the cycle-time snapshot, so the next read compares its sample against the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present; taken when req_ready is high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset within the slice |
| req_len | input | LEN_W | Transfer length in bytes |
| req_wdata | input | 32 | Write quadlet |
| cyc_count_in | input | 32 | Free-running cycle counter from the link |
| req_ready | output | 1 | High in IDLE |
| rd_valid | output | 1 | Read data beat valid |
| rd_data | output | 32 | Read data beat |
| rsp_valid | output | 1 | Response code valid |
| rsp_code | output | 2 | 0 complete, 1 type error, 2 address error |
| expiry_us | output | 32 | Split-transaction expiry in microseconds |

## Verification
Some rules are checked by assertions on every cycle. There is always exactly one active phase. The expiry never falls below its floor and changes only after a timeout write. The low bus-time bits stay clear, and bus time moves only by a 128 step or by a write. The fixed broadcast bits never change. An error response never follows a data beat, and every read burst ends in a response. Other behaviour can only be shown by the bench scenarios: the exact masked values a write leaves behind, the expiry value for particular timeout settings, and whether the wrap test uses a fresh sample or a written snapshot. The scenarios also cover the modulo-2^32 rollover of bus time, two samples taken within one block read, and the placement of the range check at offsets 0x10 and 0x14.

// File: rtl/st_pkg.sv
package st_pkg;

    typedef enum logic [1:0] {
        RSP_COMPLETE = 2'd0,
        RSP_TYPE_ERR = 2'd1,
        RSP_ADDR_ERR = 2'd2
    } rsp_code_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_READ = 2'd1,
        ST_RESP = 2'd2
    } fsm_e;

    // Quadlet indices of the slice; block reads walk them in rising order.
    localparam int unsigned IDX_SPLIT_HI = 0;
    localparam int unsigned IDX_SPLIT_LO = 1;
    localparam int unsigned IDX_CYCLE    = 2;
    localparam int unsigned IDX_BUS      = 3;
    localparam int unsigned IDX_BCAST    = 5;

    // Contiguous implemented run ends before this index; BCAST stands alone.
    localparam int unsigned IDX_RUN_END  = 4;

    localparam int unsigned HI_W         = 3;
    localparam int unsigned LO_W         = 13;
    localparam int unsigned LO_LSB       = 19;
    localparam int unsigned LO_RESET     = 800;
    localparam int unsigned BCAST_CHAN   = 31;

endpackage

// File: rtl/st_range_check.sv
module st_range_check #(
    parameter int unsigned IDX_W     = 10,
    parameter int unsigned CNT_W     = 10,
    parameter int unsigned RUN_END   = 4,
    parameter int unsigned SOLO_IDX  = 5
) (
    input  logic [IDX_W-1:0] start_idx,
    input  logic [CNT_W-1:0] count,
    output logic             ok
);
    localparam int unsigned SUM_W = ((IDX_W > CNT_W) ? IDX_W : CNT_W) + 1;

    logic [SUM_W-1:0] end_excl;
    logic             in_run;
    logic             solo;

    always_comb begin
        end_excl = SUM_W'(start_idx) + SUM_W'(count);
        in_run   = (end_excl <= SUM_W'(RUN_END));
        solo     = (start_idx == IDX_W'(SOLO_IDX)) && (count == CNT_W'(1));
        ok       = in_run || solo;
    end
endmodule

// File: rtl/st_expiry_calc.sv
module st_expiry_calc #(
    parameter int unsigned HI_W       = 3,
    parameter int unsigned LO_W       = 13,
    parameter int unsigned OUT_W      = 32,
    parameter int unsigned US_PER_SEC = 1000000,
    parameter int unsigned US_PER_TICK = 125,
    parameter int unsigned MIN_US     = 100000
) (
    input  logic [HI_W-1:0]  sec_field,
    input  logic [LO_W-1:0]  tick_field,
    output logic [OUT_W-1:0] expiry
);
    logic [OUT_W-1:0] raw_us;

    always_comb begin
        raw_us = OUT_W'(sec_field) * OUT_W'(US_PER_SEC)
               + OUT_W'(tick_field) * OUT_W'(US_PER_TICK);
        expiry = (raw_us < OUT_W'(MIN_US)) ? OUT_W'(MIN_US) : raw_us;
    end
endmodule

// File: rtl/st_bus_clock.sv
module st_bus_clock #(
    parameter int unsigned W         = 32,
    parameter int unsigned SEC_SHIFT = 25,
    parameter int unsigned BUS_LSB   = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sample_en,
    input  logic [W-1:0] cyc_in,
    input  logic         wr_cyc_en,
    input  logic         wr_bus_en,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] rd_cycle,
    output logic [W-1:0] rd_bus,
    output logic [W-1:0] bus_q
);
    localparam logic [W-1:0] BUS_STEP = W'(1) << BUS_LSB;
    localparam logic [W-1:0] BUS_MASK = ~(BUS_STEP - W'(1));

    logic [W-1:0] cyc_q;
    logic         wrapped;
    logic [W-1:0] bus_adv;

    always_comb begin
        wrapped  = (cyc_in < cyc_q);
        bus_adv  = bus_q + (wrapped ? BUS_STEP : '0);
        rd_cycle = cyc_in;
        rd_bus   = bus_adv | (cyc_in >> SEC_SHIFT);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc_q <= '0;
            bus_q <= '0;
        end else begin
            if (wr_cyc_en) begin
                cyc_q <= wdata;
            end else if (sample_en) begin
                cyc_q <= cyc_in;
            end
            if (wr_bus_en) begin
                bus_q <= wdata & BUS_MASK;
            end else if (sample_en) begin
                bus_q <= bus_adv;
            end
        end
    end
endmodule

// File: rtl/st_split_bus_regs.sv
module st_split_bus_regs
    import st_pkg::*;
#(
    parameter int unsigned ADDR_W        = 12,
    parameter int unsigned LEN_W         = 10,
    parameter int unsigned US_PER_SEC    = 1000000,
    parameter int unsigned US_PER_TICK   = 125,
    parameter int unsigned MIN_EXPIRY_US = 100000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic [31:0]       req_wdata,
    input  logic [31:0]       cyc_count_in,
    output logic              req_ready,
    output logic              rd_valid,
    output logic [31:0]       rd_data,
    output logic              rsp_valid,
    output logic [1:0]        rsp_code,
    output logic [31:0]       expiry_us
);
    localparam int unsigned IDX_W = ADDR_W - 2;

    fsm_e              state_q, state_d;
    rsp_code_e         code_q, dec_code;
    logic [IDX_W-1:0]  beat_idx_q;
    logic [LEN_W-1:0]  beats_left_q;

    logic [IDX_W-1:0]  start_idx;
    logic [LEN_W-1:0]  nbeats;
    logic              misalign;
    logic              range_ok;
    logic              accept;
    logic              wr_go;
    logic              wr_hi, wr_lo, wr_cyc, wr_bus, wr_bc;
    logic              sample_en;
    logic              split_wr;

    logic [HI_W-1:0]   split_hi_q;
    logic [LO_W-1:0]   split_lo_q;
    logic              bc_valid_q;
    logic [31:0]       bcast_word;
    logic [31:0]       rd_cycle, rd_bus, bus_time_q;
    logic [31:0]       beat_word;

    // Request decode
    always_comb begin
        start_idx = req_addr[ADDR_W-1:2];
        nbeats    = req_len >> 2;
        misalign  = (req_addr[1:0] != 2'b00) || (req_len[1:0] != 2'b00)
                 || (req_len == '0);
    end

    st_range_check #(
        .IDX_W    (IDX_W),
        .CNT_W    (LEN_W),
        .RUN_END  (IDX_RUN_END),
        .SOLO_IDX (IDX_BCAST)
    ) range_i (
        .start_idx (start_idx),
        .count     (nbeats),
        .ok        (range_ok)
    );

    always_comb begin
        dec_code = RSP_COMPLETE;
        if (misalign) begin
            dec_code = RSP_TYPE_ERR;
        end else if (req_write && (nbeats != LEN_W'(1))) begin
            dec_code = RSP_TYPE_ERR;
        end else if (!range_ok) begin
            dec_code = RSP_ADDR_ERR;
        end
    end

    always_comb begin
        accept    = (state_q == ST_IDLE) && req_valid;
        wr_go     = accept && req_write && (dec_code == RSP_COMPLETE);
        wr_hi     = wr_go && (start_idx == IDX_W'(IDX_SPLIT_HI));
        wr_lo     = wr_go && (start_idx == IDX_W'(IDX_SPLIT_LO));
        wr_cyc    = wr_go && (start_idx == IDX_W'(IDX_CYCLE));
        wr_bus    = wr_go && (start_idx == IDX_W'(IDX_BUS));
        wr_bc     = wr_go && (start_idx == IDX_W'(IDX_BCAST));
        split_wr  = wr_hi || wr_lo;
        sample_en = (state_q == ST_READ)
                 && ((beat_idx_q == IDX_W'(IDX_CYCLE)) || (beat_idx_q == IDX_W'(IDX_BUS)));
    end

    // Stored fields: only writable bits are kept
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            split_hi_q <= '0;
            split_lo_q <= LO_W'(LO_RESET);
            bc_valid_q <= 1'b0;
        end else begin
            if (wr_hi) split_hi_q <= req_wdata[HI_W-1:0];
            if (wr_lo) split_lo_q <= req_wdata[LO_LSB +: LO_W];
            if (wr_bc) bc_valid_q <= req_wdata[30];
        end
    end

    assign bcast_word = {1'b1, bc_valid_q, 24'd0, 6'(BCAST_CHAN)};

    st_expiry_calc #(
        .HI_W        (HI_W),
        .LO_W        (LO_W),
        .OUT_W       (32),
        .US_PER_SEC  (US_PER_SEC),
        .US_PER_TICK (US_PER_TICK),
        .MIN_US      (MIN_EXPIRY_US)
    ) expiry_i (
        .sec_field  (split_hi_q),
        .tick_field (split_lo_q),
        .expiry     (expiry_us)
    );

    st_bus_clock #(
        .W         (32),
        .SEC_SHIFT (25),
        .BUS_LSB   (7)
    ) clock_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .sample_en (sample_en),
        .cyc_in    (cyc_count_in),
        .wr_cyc_en (wr_cyc),
        .wr_bus_en (wr_bus),
        .wdata     (req_wdata),
        .rd_cycle  (rd_cycle),
        .rd_bus    (rd_bus),
        .bus_q     (bus_time_q)
    );

    // Beat multiplexer
    always_comb begin
        beat_word = '0;
        if (beat_idx_q == IDX_W'(IDX_SPLIT_HI))      beat_word = 32'(split_hi_q);
        else if (beat_idx_q == IDX_W'(IDX_SPLIT_LO)) beat_word = {split_lo_q, 19'd0};
        else if (beat_idx_q == IDX_W'(IDX_CYCLE))    beat_word = rd_cycle;
        else if (beat_idx_q == IDX_W'(IDX_BUS))      beat_word = rd_bus;
        else if (beat_idx_q == IDX_W'(IDX_BCAST))    beat_word = bcast_word;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid) begin
                state_d = (!req_write && (dec_code == RSP_COMPLETE)) ? ST_READ : ST_RESP;
            end
            ST_READ: if (beats_left_q == LEN_W'(1)) state_d = ST_RESP;
            ST_RESP: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register and burst control
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= ST_IDLE;
            code_q       <= RSP_COMPLETE;
            beat_idx_q   <= '0;
            beats_left_q <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                code_q       <= dec_code;
                beat_idx_q   <= start_idx;
                beats_left_q <= nbeats;
            end else if (state_q == ST_READ) begin
                beat_idx_q   <= beat_idx_q + IDX_W'(1);
                beats_left_q <= beats_left_q - LEN_W'(1);
            end
        end
    end

    // Outputs
    always_comb begin
        req_ready = (state_q == ST_IDLE);
        rd_valid  = (state_q == ST_READ);
        rsp_valid = (state_q == ST_RESP);
        rsp_code  = code_q;
        rd_data   = (state_q == ST_READ) ? beat_word : '0;
    end
endmodule

// File: rtl/st_split_bus_regs_chk.sv
module st_split_bus_regs_chk #(
    parameter int unsigned MIN_EXPIRY_US = 100000
) (
    input logic        clk,
    input logic        rst_n,
    input logic        req_ready,
    input logic        rd_valid,
    input logic        rsp_valid,
    input logic [1:0]  rsp_code,
    input logic [31:0] expiry_us,
    input logic [31:0] bus_time_q,
    input logic        split_wr,
    input logic        bus_wr,
    input logic [31:0] bcast_word
);
    p_one_phase_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({req_ready, rd_valid, rsp_valid}) == 1);

    p_expiry_floor_r4: assert property (@(posedge clk) disable iff (!rst_n)
        expiry_us >= 32'(MIN_EXPIRY_US));

    p_expiry_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(split_wr) |-> $stable(expiry_us));

    p_bus_low_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_time_q[6:0] == 7'd0);

    p_bus_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(bus_time_q) && !$past(bus_wr)) |-> (bus_time_q == $past(bus_time_q) + 32'd128));

    p_bcast_fixed_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bcast_word[31] && (bcast_word[29:0] == 30'd31));

    p_err_no_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && (rsp_code != 2'd0)) |-> !$past(rd_valid));

    p_burst_ends_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rd_valid) |-> rsp_valid);
endmodule

bind st_split_bus_regs st_split_bus_regs_chk #(
    .MIN_EXPIRY_US (MIN_EXPIRY_US)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_ready  (req_ready),
    .rd_valid   (rd_valid),
    .rsp_valid  (rsp_valid),
    .rsp_code   (rsp_code),
    .expiry_us  (expiry_us),
    .bus_time_q (bus_time_q),
    .split_wr   (split_wr),
    .bus_wr     (wr_bus),
    .bcast_word (bcast_word)
);

// File: tb/st_split_bus_regs_tb_top.sv
`timescale 1ns/1ps
module st_split_bus_regs_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [11:0] req_addr = '0;
    logic [9:0]  req_len = '0;
    logic [31:0] req_wdata = '0;
    logic [31:0] cyc_count_in = '0;
    logic        req_ready, rd_valid, rsp_valid;
    logic [31:0] rd_data, expiry_us;
    logic [1:0]  rsp_code;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // Scoreboard: bit 32 = 1 for a response item, 0 for a data beat
    logic [32:0] exp_q[$];
    string       tag_q[$];

    // Reference model state
    logic [31:0] m_hi, m_lo, m_cyc, m_bus, m_bc;

    always #4 clk = ~clk;

    st_split_bus_regs dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_len(req_len), .req_wdata(req_wdata),
        .cyc_count_in(cyc_count_in), .req_ready(req_ready), .rd_valid(rd_valid),
        .rd_data(rd_data), .rsp_valid(rsp_valid), .rsp_code(rsp_code),
        .expiry_us(expiry_us)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] m_expiry();
        logic [31:0] v;
        v = m_hi * 32'd1000000 + (m_lo >> 19) * 32'd125;
        return (v < 32'd100000) ? 32'd100000 : v;
    endfunction

    function automatic void m_sample();
        if (cyc_count_in < m_cyc) m_bus = m_bus + 32'd128;
        m_cyc = cyc_count_in;
    endfunction

    function automatic logic [31:0] m_read(input int idx);
        case (idx)
            0: return m_hi;
            1: return m_lo;
            2: begin m_sample(); return m_cyc; end
            3: begin m_sample(); return m_bus | (m_cyc >> 25); end
            5: return m_bc;
            default: return 32'h0;
        endcase
    endfunction

    function automatic void m_write(input int idx, input logic [31:0] wd);
        case (idx)
            0: m_hi = wd & 32'h7;
            1: m_lo = wd & 32'hFFF8_0000;
            2: m_cyc = wd;
            3: m_bus = wd & 32'hFFFF_FF80;
            5: m_bc = (m_bc & ~32'h4000_0000) | (wd & 32'h4000_0000);
            default: ;
        endcase
    endfunction

    function automatic logic [1:0] m_code(input bit wr, input int addr, input int len);
        int s, n;
        if ((addr % 4) != 0 || (len % 4) != 0 || len == 0) return 2'd1;
        if (wr && len != 4) return 2'd1;
        s = addr / 4;
        n = len / 4;
        if ((s + n <= 4) || (s == 5 && n == 1)) return 2'd0;
        return 2'd2;
    endfunction

    // Driver: pushes expected items, then presents the request
    task automatic do_req(input bit wr, input int addr, input int len,
                          input logic [31:0] wd, input string tag);
        logic [1:0] c;
        c = m_code(wr, addr, len);
        if (c == 2'd0 && !wr) begin
            for (int i = 0; i < len / 4; i++) begin
                exp_q.push_back({1'b0, m_read(addr / 4 + i)});
                tag_q.push_back($sformatf("%s beat%0d", tag, i));
            end
        end
        if (c == 2'd0 && wr) m_write(addr / 4, wd);
        exp_q.push_back({1'b1, 30'd0, c});
        tag_q.push_back($sformatf("%s rsp", tag));
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = 12'(addr);
        req_len   = 10'(len);
        req_wdata = wd;
        @(posedge clk);
        #1 req_valid = 1'b0;
        do begin
            @(negedge clk);
            #1;
        end while (exp_q.size() != 0);
        @(negedge clk);
        #1;
        check(req_ready === 1'b1, "R10 ready in idle", 32'(req_ready), 32'd1);
    endtask

    // Monitor
    always @(negedge clk) begin
        if (rst_n && (rd_valid || rsp_valid)) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R10 unexpected output", rd_data, 32'h0);
            end else begin
                logic [32:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (e[32]) check(rsp_valid && !rd_valid && (rsp_code == e[1:0]), t,
                                 {29'd0, rd_valid, rsp_code}, {30'd0, e[1:0]});
                else       check(rd_valid && !rsp_valid && (rd_data == e[31:0]), t,
                                 rd_data, e[31:0]);
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        finish_run();
    end

    initial begin
        m_hi = 0; m_lo = 32'h1900_0000; m_cyc = 0; m_bus = 0; m_bc = 32'h8000_001F;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(req_ready && !rd_valid && !rsp_valid, "R3 idle after reset",
              {29'd0, req_ready, rd_valid, rsp_valid}, 32'h4);
        check(expiry_us == 32'd100000, "R3 reset expiry", expiry_us, 32'd100000);

        do_req(0, 'h00, 8, 0, "R3 reset timeout words");
        do_req(0, 'h14, 4, 0, "R3 reset broadcast");

        // Timeout masking and expiry
        do_req(1, 'h00, 4, 32'hFFFF_FFFF, "R2 hi write");
        check(expiry_us == m_expiry(), "R4 expiry 7s", expiry_us, m_expiry());
        do_req(1, 'h04, 4, 32'hFFFF_FFFF, "R2 lo write");
        check(expiry_us == m_expiry(), "R4 expiry max", expiry_us, m_expiry());
        do_req(0, 'h00, 8, 0, "R2 readback");
        do_req(1, 'h00, 4, 32'h0000_0000, "R4 hi clear");
        do_req(1, 'h04, 4, 32'h0008_0000, "R4 one tick");
        check(expiry_us == 32'd100000, "R4 clamp floor", expiry_us, 32'd100000);
        do_req(1, 'h04, 4, 32'h1F40_0000, "R4 1000 ticks");
        check(expiry_us == 32'd125000, "R4 above floor", expiry_us, 32'd125000);

        // Alignment and length errors
        do_req(0, 'h02, 4, 0, "R1 misaligned addr");
        do_req(0, 'h00, 6, 0, "R1 odd length");
        do_req(0, 'h00, 0, 0, "R1 zero length");
        do_req(1, 'h00, 8, 32'h5, "R1 long write");
        check(expiry_us == 32'd125000, "R1 long write ignored", expiry_us, 32'd125000);

        // Address errors
        do_req(0, 'h10, 4, 0, "R8 busy hole read");
        do_req(1, 'h10, 4, 32'hFFFF_FFFF, "R8 busy hole write");
        do_req(0, 'h18, 4, 0, "R8 beyond end");
        do_req(0, 'h0C, 12, 0, "R8 crossing hole");
        do_req(0, 'h14, 8, 0, "R8 past broadcast");
        do_req(1, 'h40, 4, 32'hFFFF_FFFF, "R8 far write");
        do_req(0, 'h00, 8, 0, "R8 state unchanged");

        // Cycle and bus time
        cyc_count_in = 32'h0400_0000;
        do_req(0, 'h08, 4, 0, "R5 first sample");
        do_req(0, 'h0C, 4, 0, "R6 seconds merged");
        cyc_count_in = 32'h0200_0000;
        do_req(0, 'h0C, 4, 0, "R5 wrap on bus read");
        cyc_count_in = 32'h0100_0000;
        do_req(0, 'h08, 8, 0, "R5 two samples one burst");
        do_req(1, 'h0C, 4, 32'hFFFF_FFFF, "R6 bus write mask");
        do_req(0, 'h0C, 4, 0, "R6 bus readback");
        cyc_count_in = 32'h0000_0000;
        do_req(0, 'h0C, 4, 0, "R5 bus rollover");
        do_req(1, 'h08, 4, 32'hFFFF_FFFF, "R11 cycle write");
        cyc_count_in = 32'h0000_0100;
        do_req(0, 'h08, 4, 0, "R11 compare to written");
        do_req(0, 'h0C, 4, 0, "R11 bus after wrap");

        // Broadcast channel
        do_req(1, 'h14, 4, 32'hFFFF_FFFF, "R7 set valid");
        do_req(0, 'h14, 4, 0, "R7 readback set");
        do_req(1, 'h14, 4, 32'h0000_0000, "R7 clear valid");
        do_req(0, 'h14, 4, 0, "R7 readback clear");

        // Full block read
        cyc_count_in = 32'h0600_0040;
        do_req(0, 'h00, 16, 0, "R9 four beat block");
        do_req(0, 'h04, 8, 0, "R9 two beat block");

        finish_run();
    end
endmodule